// File: doc/BRIEF.md
# Byte-Accessed 16-bit Timer with Compare Flags

This block is a 16-bit timer/counter with two 16-bit compare units, all reached by a processor over an 8-bit register bus. A single temporary byte latch is shared by every 16-bit register so that each full-width access is atomic. Software reads the counter low byte first, which also captures the high byte, and writes any 16-bit register low byte first, which is held until the high byte arrives and both bytes commit on one clock edge.

The counter advances only on cycles where the `tick` input (an already prescaled count pulse) is high. With `pwm_mode` low it counts up and wraps. With `pwm_mode` high it runs as a triangle counter under a two-state direction machine: state DIR_UP moves to DIR_DOWN on a tick taken at 0xFFFF, state DIR_DOWN moves to DIR_UP on a tick taken at 0x0000, and clearing `pwm_mode` forces DIR_UP. Each compare unit watches the counter continuously and sets a sticky flag that software clears by writing a one to the flag bit.

Register map (byte addresses): counter 0x2C low / 0x2D high, compare unit A 0x2A low / 0x2B high, compare unit B 0x28 low / 0x29 high, flags 0x2E (bit 0 = unit A, bit 1 = unit B). Unmapped reads return 0x00.

Top module: `byte_timer16`

## Requirements
- R1: After reset the counter, both compare registers, both flags and the temporary latch are zero, so every mapped address reads 0x00.
- R2: Reading 0x2C returns the live counter low byte and, on that clock edge, copies the live high byte into the temporary latch; reading 0x2D returns the latch, so a low-then-high read gives one coherent value even while counting.
- R3: Writing a compare low byte (0x2A or 0x28) only loads the temporary latch and leaves the compare register unchanged; writing its high byte (0x2B or 0x29) loads {high byte, latch} into the whole register on one edge.
- R4: Writing 0x2C loads only the latch; writing 0x2D loads {data, latch} into the counter, which holds that value for the load cycle even when `tick` is high and counts again from the next tick.
- R5: The counter changes only on cycles where `tick` is high or a counter load occurs.
- R6: With `pwm_mode` low the counter increments by one per tick and wraps from 0xFFFF to 0x0000.
- R7: With `pwm_mode` high the counter reverses at both ends without repeating them: a tick at 0xFFFF gives 0xFFFE and a tick at 0x0000 gives 0x0001.
- R8: Both bytes of each compare register are read back directly at their addresses.
- R9: A compare flag sets on a tick cycle (without counter load) in which the counter equals that compare register, and then stays set; equality without a tick does not set it.
- R10: Writing 0x2E clears each flag whose data bit is 1 (bit 0 = A, bit 1 = B) and leaves flags whose bit is 0; a set in the same cycle wins over a clear.
- R11: One latch serves all registers: the most recent low-byte write (or counter low read) supplies the low byte of the next high-byte commit, whichever register it targets.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 8 | Byte address of the access |
| bus_wdata | input | 8 | Write data byte |
| bus_wr | input | 1 | Write strobe, one cycle per byte |
| bus_rd | input | 1 | Read strobe, one cycle per byte |
| bus_rdata | output | 8 | Read data, valid in the cycle `bus_rd` is high |
| tick | input | 1 | Count enable pulse |
| pwm_mode | input | 1 | 1 selects up/down counting, 0 selects up counting |
| match_flags | output | 2 | Sticky compare flags, bit 0 unit A, bit 1 unit B |

## Verification
The assertions watch every cycle for the counter's step rules (hold without tick, increment in up mode, turn-around at both ends in triangle mode, load beating the tick), for the latch capturing the high byte on a low-byte counter read, and for the compare registers and flags changing only on a commit, a qualified match or a clear. Only the bench's scenarios show the software-visible orderings: that a high read after counting still returns the captured byte, that a low-byte write alone leaves a compare register untouched, that one latch is shared across registers, and that whole count sequences across the wrap and both turn-around points land on the expected values.

// File: rtl/t16_pkg.sv
package t16_pkg;

    localparam int BYTE_W  = 8;
    localparam int CNT_W   = 2 * BYTE_W;
    localparam int ADDR_W  = 8;
    localparam int NUM_CMP = 2;

    localparam logic [ADDR_W-1:0] ADR_CNT_LO  = 8'h2C;
    localparam logic [ADDR_W-1:0] ADR_CNT_HI  = 8'h2D;
    localparam logic [ADDR_W-1:0] ADR_FLAGS   = 8'h2E;
    localparam logic [ADDR_W-1:0] ADR_CMP0_LO = 8'h2A;

    typedef enum logic {
        DIR_UP   = 1'b0,
        DIR_DOWN = 1'b1
    } dir_e;

    // Compare unit idx sits two bytes below unit idx-1.
    function automatic logic [ADDR_W-1:0] cmp_lo_adr(input int idx);
        return ADDR_W'(int'(ADR_CMP0_LO) - 2 * idx);
    endfunction

    function automatic logic [ADDR_W-1:0] cmp_hi_adr(input int idx);
        return ADDR_W'(int'(ADR_CMP0_LO) - 2 * idx + 1);
    endfunction

endpackage

// File: rtl/t16_regbus.sv
module t16_regbus
    import t16_pkg::*;
#(
    parameter int BW = BYTE_W,
    parameter int NC = NUM_CMP
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [ADDR_W-1:0]        addr,
    input  logic [BW-1:0]            wdata,
    input  logic                     wr,
    input  logic                     rd,
    input  logic [2*BW-1:0]          cnt,
    input  logic [NC-1:0][2*BW-1:0]  cmp_vals,
    input  logic [NC-1:0]            flags,
    output logic [BW-1:0]            rdata,
    output logic                     cnt_load,
    output logic [2*BW-1:0]          load_val,
    output logic [NC-1:0]            cmp_load,
    output logic [NC-1:0]            flag_clr
);

    localparam int FW = 2 * BW;

    logic [BW-1:0] temp_q;
    logic          low_wr;
    logic          cnt_lo_rd;

    // Write decode: high bytes commit, low bytes only feed the latch.
    always_comb begin
        cnt_load  = wr && (addr == ADR_CNT_HI);
        load_val  = {wdata, temp_q};
        low_wr    = wr && (addr == ADR_CNT_LO);
        cnt_lo_rd = rd && !wr && (addr == ADR_CNT_LO);
        for (int i = 0; i < NC; i++) begin
            cmp_load[i] = wr && (addr == cmp_hi_adr(i));
            flag_clr[i] = wr && (addr == ADR_FLAGS) && wdata[i];
            if (wr && (addr == cmp_lo_adr(i))) begin
                low_wr = 1'b1;
            end
        end
    end

    // Shared temporary latch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            temp_q <= '0;
        end else if (low_wr) begin
            temp_q <= wdata;
        end else if (cnt_lo_rd) begin
            temp_q <= cnt[FW-1:BW];
        end
    end

    // Read mux.
    always_comb begin
        rdata = '0;
        if (rd) begin
            if (addr == ADR_CNT_LO) begin
                rdata = cnt[BW-1:0];
            end else if (addr == ADR_CNT_HI) begin
                rdata = temp_q;
            end else if (addr == ADR_FLAGS) begin
                rdata = BW'(flags);
            end
            for (int i = 0; i < NC; i++) begin
                if (addr == cmp_lo_adr(i)) begin
                    rdata = cmp_vals[i][BW-1:0];
                end
                if (addr == cmp_hi_adr(i)) begin
                    rdata = cmp_vals[i][FW-1:BW];
                end
            end
        end
    end

    // R2
    temp_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_lo_rd |=> temp_q == $past(cnt[FW-1:BW]));

    // R11
    temp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr && !rd) |=> $stable(temp_q));

endmodule

// File: rtl/t16_counter.sv
module t16_counter
    import t16_pkg::*;
#(
    parameter int W = CNT_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic         pwm_mode,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic [W-1:0] cnt,
    output logic         counting
);

    localparam logic [W-1:0] CNT_MAX  = '1;
    localparam logic [W-1:0] CNT_ZERO = '0;

    dir_e         dir_q, dir_d;
    logic [W-1:0] cnt_d;

    assign counting = tick && !load;

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dir_q <= DIR_UP;
        end else begin
            dir_q <= dir_d;
        end
    end

    // Next-state logic: turn around only on a counting cycle at an end.
    always_comb begin
        dir_d = dir_q;
        if (!pwm_mode) begin
            dir_d = DIR_UP;
        end else if (counting) begin
            unique case (dir_q)
                DIR_UP:   if (cnt == CNT_MAX)  dir_d = DIR_DOWN;
                DIR_DOWN: if (cnt == CNT_ZERO) dir_d = DIR_UP;
            endcase
        end
    end

    // Output logic: next count value.
    always_comb begin
        cnt_d = cnt;
        if (load) begin
            cnt_d = load_val;
        end else if (tick) begin
            if (!pwm_mode) begin
                cnt_d = cnt + 1'b1;
            end else begin
                unique case (dir_q)
                    DIR_UP:   cnt_d = (cnt == CNT_MAX)  ? cnt - 1'b1 : cnt + 1'b1;
                    DIR_DOWN: cnt_d = (cnt == CNT_ZERO) ? cnt + 1'b1 : cnt - 1'b1;
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else begin
            cnt <= cnt_d;
        end
    end

    // R5
    cnt_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !load) |=> $stable(cnt));

    // R4
    cnt_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> cnt == $past(load_val));

    // R6
    cnt_up_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!pwm_mode && tick && !load) |=> cnt == W'($past(cnt) + 1'b1));

    // R7
    cnt_top_turn_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pwm_mode && tick && !load && cnt == CNT_MAX) |=> cnt == CNT_MAX - 1'b1);

    // R7
    cnt_bottom_turn_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pwm_mode && tick && !load && cnt == CNT_ZERO) |=> cnt == W'(1));

endmodule

// File: rtl/t16_compare.sv
module t16_compare
    import t16_pkg::*;
#(
    parameter int W = CNT_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [W-1:0] wr_val,
    input  logic         clr,
    input  logic [W-1:0] cnt,
    input  logic         counting,
    output logic [W-1:0] value,
    output logic         flag
);

    logic hit;

    assign hit = counting && (cnt == value);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            value <= '0;
        end else if (wr_en) begin
            value <= wr_val;
        end
    end

    // Set has priority over a same-cycle clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag <= 1'b0;
        end else if (hit) begin
            flag <= 1'b1;
        end else if (clr) begin
            flag <= 1'b0;
        end
    end

    // R3
    cmp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(value));

    // R3
    cmp_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> value == $past(wr_val));

    // R9
    flag_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag) |-> $past(counting && cnt == value));

    // R9
    flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !clr) |=> flag);

    // R10
    flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !(counting && cnt == value)) |=> !flag);

endmodule

// File: rtl/byte_timer16.sv
module byte_timer16
    import t16_pkg::*;
#(
    parameter int BW = BYTE_W,
    parameter int NC = NUM_CMP
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BW-1:0]     bus_wdata,
    input  logic              bus_wr,
    input  logic              bus_rd,
    output logic [BW-1:0]     bus_rdata,
    input  logic              tick,
    input  logic              pwm_mode,
    output logic [NC-1:0]     match_flags
);

    localparam int FW = 2 * BW;

    logic [FW-1:0]         cnt;
    logic                  counting;
    logic                  cnt_load;
    logic [FW-1:0]         load_val;
    logic [NC-1:0]         cmp_load;
    logic [NC-1:0]         flag_clr;
    logic [NC-1:0][FW-1:0] cmp_vals;

    t16_regbus #(.BW(BW), .NC(NC)) regbus_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .addr     (bus_addr),
        .wdata    (bus_wdata),
        .wr       (bus_wr),
        .rd       (bus_rd),
        .cnt      (cnt),
        .cmp_vals (cmp_vals),
        .flags    (match_flags),
        .rdata    (bus_rdata),
        .cnt_load (cnt_load),
        .load_val (load_val),
        .cmp_load (cmp_load),
        .flag_clr (flag_clr)
    );

    t16_counter #(.W(FW)) counter_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .pwm_mode (pwm_mode),
        .load     (cnt_load),
        .load_val (load_val),
        .cnt      (cnt),
        .counting (counting)
    );

    for (genvar g = 0; g < NC; g++) begin : g_cmp
        t16_compare #(.W(FW)) compare_i (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_en    (cmp_load[g]),
            .wr_val   (load_val),
            .clr      (flag_clr[g]),
            .cnt      (cnt),
            .counting (counting),
            .value    (cmp_vals[g]),
            .flag     (match_flags[g])
        );
    end

endmodule

// File: tb/byte_timer16_tb_top.sv
module byte_timer16_tb_top;

    localparam int CLK_PERIOD = 10;

    localparam logic [7:0] A_CNT_LO = 8'h2C;
    localparam logic [7:0] A_CNT_HI = 8'h2D;
    localparam logic [7:0] A_FLG    = 8'h2E;
    localparam logic [7:0] A_CA_LO  = 8'h2A;
    localparam logic [7:0] A_CA_HI  = 8'h2B;
    localparam logic [7:0] A_CB_LO  = 8'h28;
    localparam logic [7:0] A_CB_HI  = 8'h29;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic       bus_wr = 1'b0;
    logic       bus_rd = 1'b0;
    logic [7:0] bus_rdata;
    logic       tick = 1'b0;
    logic       pwm_mode = 1'b0;
    logic [1:0] match_flags;

    int n_checks = 0;
    int n_fails  = 0;

    byte_timer16 dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .bus_addr    (bus_addr),
        .bus_wdata   (bus_wdata),
        .bus_wr      (bus_wr),
        .bus_rd      (bus_rd),
        .bus_rdata   (bus_rdata),
        .tick        (tick),
        .pwm_mode    (pwm_mode),
        .match_flags (match_flags)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic chk(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    // All bus tasks start and end at a falling edge.
    task automatic wr8(input logic [7:0] a, input logic [7:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd8(input logic [7:0] a, output logic [7:0] d);
        bus_addr = a; bus_rd = 1'b1;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic wr16(input logic [7:0] lo_a, input logic [7:0] hi_a, input logic [15:0] v);
        wr8(lo_a, v[7:0]);
        wr8(hi_a, v[15:8]);
    endtask

    task automatic rd16(input logic [7:0] lo_a, input logic [7:0] hi_a, output logic [15:0] v);
        logic [7:0] lo, hi;
        rd8(lo_a, lo);
        rd8(hi_a, hi);
        v = {hi, lo};
    endtask

    task automatic ticks(input int n);
        tick = 1'b1;
        repeat (n) @(negedge clk);
        tick = 1'b0;
    endtask

    task automatic t_reset;
        logic [7:0] d;
        logic [7:0] adrs [7] = '{A_CNT_LO, A_CNT_HI, A_FLG, A_CA_LO, A_CA_HI, A_CB_LO, A_CB_HI};
        for (int i = 0; i < 7; i++) begin
            rd8(adrs[i], d);
            chk("R1 reset read", d, 0);
        end
        chk("R1 reset flags", match_flags, 0);
    endtask

    task automatic t_compare_write;
        logic [7:0]  d;
        logic [15:0] v;
        wr8(A_CB_LO, 8'h34);
        rd8(A_CB_LO, d);
        chk("R3 low write alone leaves register", d, 8'h00);
        wr8(A_CB_HI, 8'h12);
        rd16(A_CB_LO, A_CB_HI, v);
        chk("R3 R8 commit B", v, 16'h1234);
        wr8(A_CA_LO, 8'h55);
        wr8(A_CB_LO, 8'h66);
        wr8(A_CA_HI, 8'h77);
        rd16(A_CA_LO, A_CA_HI, v);
        chk("R11 shared latch last low wins", v, 16'h7766);
        rd16(A_CB_LO, A_CB_HI, v);
        chk("R11 B untouched by low write", v, 16'h1234);
    endtask

    task automatic t_counter_load;
        logic [15:0] v;
        wr8(A_CNT_LO, 8'h00);
        tick = 1'b1;
        wr8(A_CNT_HI, 8'h01);
        tick = 1'b0;
        rd16(A_CNT_LO, A_CNT_HI, v);
        chk("R4 load wins over tick", v, 16'h0100);
        ticks(1);
        rd16(A_CNT_LO, A_CNT_HI, v);
        chk("R4 counts after load", v, 16'h0101);
        repeat (5) @(negedge clk);
        rd16(A_CNT_LO, A_CNT_HI, v);
        chk("R5 no tick holds", v, 16'h0101);
    endtask

    task automatic t_coherent_read;
        logic [7:0]  lo, hi;
        logic [15:0] v;
        wr16(A_CNT_LO, A_CNT_HI, 16'h12FF);
        tick = 1'b1;
        rd8(A_CNT_LO, lo);
        rd8(A_CNT_HI, hi);
        tick = 1'b0;
        chk("R2 live low byte", lo, 8'hFF);
        chk("R2 high from latch", hi, 8'h12);
        rd16(A_CNT_LO, A_CNT_HI, v);
        chk("R2 counter after two ticks", v, 16'h1301);
    endtask

    task automatic t_wrap;
        logic [15:0] v;
        wr16(A_CNT_LO, A_CNT_HI, 16'hFFFE);
        ticks(3);
        rd16(A_CNT_LO, A_CNT_HI, v);
        chk("R6 wrap", v, 16'h0001);
    endtask

    task automatic t_pwm;
        logic [15:0] v;
        pwm_mode = 1'b1;
        wr16(A_CNT_LO, A_CNT_HI, 16'hFFFE);
        ticks(3);
        rd16(A_CNT_LO, A_CNT_HI, v);
        chk("R7 top turn", v, 16'hFFFD);
        wr16(A_CNT_LO, A_CNT_HI, 16'h0002);
        ticks(4);
        rd16(A_CNT_LO, A_CNT_HI, v);
        chk("R7 bottom turn", v, 16'h0002);
        pwm_mode = 1'b0;
    endtask

    task automatic t_flags;
        logic [7:0] d;
        wr8(A_FLG, 8'h03);
        rd8(A_FLG, d);
        chk("R10 clear both", d, 8'h00);
        wr16(A_CA_LO, A_CA_HI, 16'h0010);
        wr16(A_CNT_LO, A_CNT_HI, 16'h000E);
        ticks(3);
        rd8(A_FLG, d);
        chk("R9 flag A sets on match", d, 8'h01);
        ticks(5);
        rd8(A_FLG, d);
        chk("R9 flag sticky", d, 8'h01);
        wr8(A_FLG, 8'h02);
        rd8(A_FLG, d);
        chk("R10 zero bit leaves A", d, 8'h01);
        wr8(A_FLG, 8'h01);
        rd8(A_FLG, d);
        chk("R10 clear A", d, 8'h00);
        wr16(A_CNT_LO, A_CNT_HI, 16'h0010);
        repeat (3) @(negedge clk);
        rd8(A_FLG, d);
        chk("R9 equal without tick no set", d, 8'h00);
        tick = 1'b1;
        wr8(A_FLG, 8'h01);
        tick = 1'b0;
        chk("R10 set beats clear", match_flags, 2'b01);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_compare_write();
        t_counter_load();
        t_coherent_read();
        t_wrap();
        t_pwm();
        t_flags();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

endmodule